// File: doc/BRIEF.md
# Clock-Pair Skew Error Detector

This block watches two clocks that are meant to move together: a count clock and a companion check clock. A rising edge on the count clock should be answered by a falling edge on the check clock within a programmable number of system-clock cycles. A falling edge on the check clock that comes first should be answered by a rising count edge within a second programmable window. Each event left unanswered counts as one error. Once three errors have been counted, a sticky error flag goes high and stays high until master reset.

Both monitored inputs are asynchronous. Each passes through a two-flop synchronizer and then an edge detector. Edges are ignored until the pipeline holds real samples. Only one window can be open at a time. An edge that answers an open window is used up. An edge that answers nothing opens the window for the opposite direction. The monitor stays inert until the check clock has shown a rising edge after reset. A check clock that is tied high or low therefore turns detection off.

Top module: `clk_pair_skew_monitor`

## Requirements
- R1: While master reset is high, and on the first cycle after it is released, the error flag is 0 and the error count is cleared.
- R2: A count-clock rise answered by a check-clock fall d cycles later (0 ≤ d ≤ window A, where d = 0 means the same cycle) adds no error. If d exceeds window A, the rise adds one error.
- R3: A check-clock fall answered by a count-clock rise d cycles later (0 ≤ d ≤ window B) adds no error. If d exceeds window B, the fall adds one error.
- R4: A window value W accepts an answering edge in the W-th cycle after the leading edge and rejects one in the (W+1)-th cycle.
- R5: An answering-type edge that arrives with no window open is not discarded. It opens the window for the opposite direction, so a late answer costs a second error when it is itself left unanswered.
- R6: A second leading edge of the same kind that arrives while its window is open adds one error for the old window and opens a fresh one.
- R7: The error flag rises when the count reaches three. The count saturates at three, and the flag stays high until master reset.
- R8: Until a rising check-clock edge is seen after reset, no error is counted. A check clock held constantly low or high keeps the flag at 0.
- R9: A window value of 0 accepts only an answer in the same cycle as the leading edge. Otherwise the error is counted immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mstRst | input | 1 | Synchronous master reset, active high |
| cntClk | input | 1 | Count clock, asynchronous |
| chkClk | input | 1 | Check clock, asynchronous |
| winA | input | WIN_W (16) | Cycles allowed after a count rise for the check fall |
| winB | input | WIN_W (16) | Cycles allowed after a check fall for the count rise |
| errFlag | output | 1 | High once three errors have been counted |

## Verification
The bench builds the block with its defaults: 16-bit windows and a limit of three errors. It drives window values 0 to 4 only, so every combination of window value and edge skew from 0 to 6 cycles is covered in both lead directions. The skew range straddles each window's last accepted cycle, so boundary acceptance and the zero-length window are swept exhaustively. The same small windows make the second error from a late answer (which opens the reverse window) show up within each trial. Separate scenarios use long windows to cover restart of an open window, saturation and stickiness of the flag, and the inert behaviour under a tied-off check clock.

// File: rtl/skew_mon_pkg.sv
package skew_mon_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_CHK = 2'd1,
    ST_WAIT_CNT = 2'd2
  } monState_t;

  typedef struct packed {
    logic loadA;
    logic loadB;
    logic decr;
    logic errInc;
  } monStrobe_t;

endpackage

// File: rtl/skew_mon_datapath.sv
module skew_mon_datapath
  import skew_mon_pkg::*;
#(
  parameter int WIN_W     = 16,
  parameter int ERR_LIMIT = 3,
  parameter int SYNC_LEN  = 2
) (
  input  logic             clk,
  input  logic             mstRst,
  input  logic             cntClk,
  input  logic             chkClk,
  input  logic [WIN_W-1:0] winA,
  input  logic [WIN_W-1:0] winB,
  input  monStrobe_t       stb,
  output logic             cntRise,
  output logic             chkFall,
  output logic             chkRise,
  output logic             timerLast,
  output logic             winAZero,
  output logic             winBZero,
  output logic             errFlag
);

  localparam int CNT_W   = $clog2(ERR_LIMIT + 1);
  localparam int PRIME_N = SYNC_LEN + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ERR_LIMIT);

  logic [1:0]         sampleLast;
  logic [PRIME_N-1:0] primeSr;
  logic [WIN_W-1:0]   timer;
  logic [CNT_W-1:0]   errCnt;
  logic [1:0]         syncOut;

  // two synchronizer chains, one per monitored input
  for (genvar g = 0; g < 2; g++) begin : g_sync
    logic [SYNC_LEN-1:0] chain;
    logic rawIn;
    assign rawIn = (g == 0) ? cntClk : chkClk;
    always_ff @(posedge clk) begin
      if (mstRst) chain <= '0;
      else        chain <= {chain[SYNC_LEN-2:0], rawIn};
    end
    assign syncOut[g] = chain[SYNC_LEN-1];
  end

  always_ff @(posedge clk) begin
    if (mstRst) begin
      sampleLast <= '0;
      primeSr    <= '0;
    end else begin
      sampleLast <= syncOut;
      primeSr    <= {primeSr[PRIME_N-2:0], 1'b1};
    end
  end

  logic primed;
  assign primed  = primeSr[PRIME_N-1];
  assign cntRise = primed &  syncOut[0] & ~sampleLast[0];
  assign chkFall = primed & ~syncOut[1] &  sampleLast[1];
  assign chkRise = primed &  syncOut[1] & ~sampleLast[1];

  // shared window timer
  always_ff @(posedge clk) begin
    if (mstRst)         timer <= '0;
    else if (stb.loadA) timer <= winA;
    else if (stb.loadB) timer <= winB;
    else if (stb.decr)  timer <= timer - 1'b1;
  end

  assign timerLast = (timer == WIN_W'(1));
  assign winAZero  = (winA == '0);
  assign winBZero  = (winB == '0);

  // saturating error counter
  always_ff @(posedge clk) begin
    if (mstRst)                            errCnt <= '0;
    else if (stb.errInc && errCnt != CNT_MAX) errCnt <= errCnt + 1'b1;
  end

  assign errFlag = (errCnt == CNT_MAX);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    mstRst |=> (errCnt == '0 && !errFlag));  // R1

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (mstRst)
    !stb.errInc |=> $stable(errCnt));  // R2

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (mstRst)
    (errCnt == CNT_MAX) |=> (errCnt == CNT_MAX));  // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (mstRst)
    errFlag |=> errFlag);  // R7

endmodule

// File: rtl/skew_mon_ctrl.sv
module skew_mon_ctrl
  import skew_mon_pkg::*;
(
  input  logic       clk,
  input  logic       mstRst,
  input  logic       cntRise,
  input  logic       chkFall,
  input  logic       chkRise,
  input  logic       timerLast,
  input  logic       winAZero,
  input  logic       winBZero,
  output monStrobe_t stb
);

  monState_t state, stateNxt;
  logic armed;

  always_ff @(posedge clk) begin
    if (mstRst) begin
      state <= ST_IDLE;
      armed <= 1'b0;
    end else begin
      state <= stateNxt;
      armed <= armed | chkRise;
    end
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (armed) begin
          if (cntRise && !chkFall) begin
            if (winAZero) stb.errInc = 1'b1;
            else begin stb.loadA = 1'b1; stateNxt = ST_WAIT_CHK; end
          end else if (chkFall && !cntRise) begin
            if (winBZero) stb.errInc = 1'b1;
            else begin stb.loadB = 1'b1; stateNxt = ST_WAIT_CNT; end
          end
        end
      end
      ST_WAIT_CHK: begin
        if (chkFall) begin
          stateNxt = ST_IDLE;
          if (cntRise) begin
            if (winAZero) stb.errInc = 1'b1;
            else begin stb.loadA = 1'b1; stateNxt = ST_WAIT_CHK; end
          end
        end else if (cntRise) begin
          stb.errInc = 1'b1;
          if (winAZero) stateNxt = ST_IDLE;
          else          stb.loadA = 1'b1;
        end else if (timerLast) begin
          stb.errInc = 1'b1;
          stateNxt   = ST_IDLE;
        end else begin
          stb.decr = 1'b1;
        end
      end
      ST_WAIT_CNT: begin
        if (cntRise) begin
          stateNxt = ST_IDLE;
          if (chkFall) begin
            if (winBZero) stb.errInc = 1'b1;
            else begin stb.loadB = 1'b1; stateNxt = ST_WAIT_CNT; end
          end
        end else if (chkFall) begin
          stb.errInc = 1'b1;
          if (winBZero) stateNxt = ST_IDLE;
          else          stb.loadB = 1'b1;
        end else if (timerLast) begin
          stb.errInc = 1'b1;
          stateNxt   = ST_IDLE;
        end else begin
          stb.decr = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (mstRst)
    !armed |-> !stb.errInc);  // R8

  AST_RESTART_ERR: assert property (@(posedge clk) disable iff (mstRst)
    (state == ST_WAIT_CHK && cntRise && !chkFall) |=> (state == ST_WAIT_CHK || winAZero));  // R6

  AST_PAIR_CLOSES: assert property (@(posedge clk) disable iff (mstRst)
    (state == ST_WAIT_CNT && cntRise && !chkFall) |=> (state == ST_IDLE));  // R3

endmodule

// File: rtl/clk_pair_skew_monitor.sv
module clk_pair_skew_monitor
  import skew_mon_pkg::*;
#(
  parameter int WIN_W     = 16,
  parameter int ERR_LIMIT = 3
) (
  input  logic             clk,
  input  logic             mstRst,
  input  logic             cntClk,
  input  logic             chkClk,
  input  logic [WIN_W-1:0] winA,
  input  logic [WIN_W-1:0] winB,
  output logic             errFlag
);

  monStrobe_t stb;
  logic cntRise, chkFall, chkRise, timerLast, winAZero, winBZero;

  skew_mon_datapath #(.WIN_W(WIN_W), .ERR_LIMIT(ERR_LIMIT), .SYNC_LEN(2)) u_dp (
    .clk(clk), .mstRst(mstRst), .cntClk(cntClk), .chkClk(chkClk),
    .winA(winA), .winB(winB), .stb(stb),
    .cntRise(cntRise), .chkFall(chkFall), .chkRise(chkRise),
    .timerLast(timerLast), .winAZero(winAZero), .winBZero(winBZero),
    .errFlag(errFlag)
  );

  skew_mon_ctrl u_ctrl (
    .clk(clk), .mstRst(mstRst), .cntRise(cntRise), .chkFall(chkFall),
    .chkRise(chkRise), .timerLast(timerLast), .winAZero(winAZero),
    .winBZero(winBZero), .stb(stb)
  );

endmodule

// File: tb/clk_pair_skew_monitor_tb.sv
module clk_pair_skew_monitor_tb;

  logic clk = 0;
  logic mstRst = 1;
  logic cntClk = 0;
  logic chkClk = 0;
  logic [15:0] winA = 16'd2;
  logic [15:0] winB = 16'd2;
  logic errFlag;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  clk_pair_skew_monitor u_dut (
    .clk(clk), .mstRst(mstRst), .cntClk(cntClk), .chkClk(chkClk),
    .winA(winA), .winB(winB), .errFlag(errFlag)
  );

  task automatic check(input logic got, input logic exp, input string req);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: errFlag=%0b expected %0b", req, got, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reset, then optionally raise the check clock to arm detection
  task automatic doReset(input logic chkLevel, input bit arm);
    @(negedge clk);
    mstRst = 1; cntClk = 0; chkClk = chkLevel;
    waitN(3);
    check(errFlag, 1'b0, "R1 during reset");
    mstRst = 0;
    waitN(1);
    check(errFlag, 1'b0, "R1 after reset");
    waitN(8);
    if (arm) begin chkClk = 1; waitN(8); end
  endtask

  // count rise leads, check fall follows d cycles later
  task automatic cntLead(input int d);
    @(negedge clk);
    cntClk = 1;
    if (d == 0) chkClk = 0;
    else begin waitN(d); chkClk = 0; end
    waitN(20); chkClk = 1;
    waitN(5);  cntClk = 0;
    waitN(20);
  endtask

  // check fall leads, count rise follows d cycles later
  task automatic chkLead(input int d);
    @(negedge clk);
    chkClk = 0;
    if (d == 0) cntClk = 1;
    else begin waitN(d); cntClk = 1; end
    waitN(20); cntClk = 0;
    waitN(5);  chkClk = 1;
    waitN(20);
  endtask

  initial begin
    // exhaustive sweep, count-clock-led pairs (window B small, so a late
    // answer also costs a reverse-window error)
    for (int w = 0; w <= 4; w++) begin
      for (int d = 0; d <= 6; d++) begin
        winA = 16'(w); winB = 16'd2;
        doReset(1'b0, 1);
        cntLead(d);
        check(errFlag, 1'b0, $sformatf("R2 one trial w=%0d d=%0d", w, d));
        cntLead(d);
        check(errFlag, (d > w), $sformatf("R2/R4/R5/R9 two trials w=%0d d=%0d", w, d));
      end
    end
    // exhaustive sweep, check-clock-led pairs
    for (int w = 0; w <= 4; w++) begin
      for (int d = 0; d <= 6; d++) begin
        winB = 16'(w); winA = 16'd2;
        doReset(1'b0, 1);
        chkClk = 1; waitN(2);
        chkLead(d);
        check(errFlag, 1'b0, $sformatf("R3 one trial w=%0d d=%0d", w, d));
        chkLead(d);
        check(errFlag, (d > w), $sformatf("R3/R4/R5/R9 two trials w=%0d d=%0d", w, d));
      end
    end
    // restart of an open window: one error per group
    winA = 16'd100; winB = 16'd100;
    doReset(1'b0, 1);
    for (int grp = 1; grp <= 3; grp++) begin
      cntClk = 1; waitN(3); cntClk = 0; waitN(3); cntClk = 1; waitN(2);
      chkClk = 0; waitN(10); chkClk = 1; waitN(3); cntClk = 0; waitN(10);
      check(errFlag, (grp >= 3), $sformatf("R6 restart group %0d", grp));
    end
    // sticky after saturation: well-paired traffic keeps the flag high
    for (int k = 0; k < 4; k++) cntLead(1);
    check(errFlag, 1'b1, "R7 flag sticky under paired traffic");
    doReset(1'b1, 0);
    check(errFlag, 1'b0, "R1 flag cleared by reset");
    // check clock held low: count clock toggling alone
    winA = 16'd1; winB = 16'd1;
    doReset(1'b0, 0);
    for (int k = 0; k < 8; k++) begin cntClk = 1; waitN(10); cntClk = 0; waitN(10); end
    check(errFlag, 1'b0, "R8 check clock held low");
    // check clock held high from reset
    doReset(1'b1, 0);
    for (int k = 0; k < 8; k++) begin cntClk = 1; waitN(10); cntClk = 0; waitN(10); end
    check(errFlag, 1'b0, "R8 check clock held high");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run incomplete, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule